// File: doc/BRIEF.md
# SPI Channel Buffer Status Logic

This block keeps the status of one SPI channel. It tracks whether the single-word transmit holding register is empty and whether the single-word receive holding register holds a word. It also keeps an end-of-transfer indicator. It registers the full and empty levels of the channel's transmit and receive FIFOs. Everything is reported in one 32-bit read-only status word.

All inputs except the FIFO levels are one-cycle event strobes. They come from the channel enable, from host byte accesses to the transmit and receive registers, and from the shifter (transmit load, receive capture, transfer end). A host access changes a flag only when it targets the most significant byte of the SPI word, so a multi-byte word is finished by its last byte. Every flag is registered and changes on the clock edge after its strobe. Reset is synchronous and active high.

No data passes through the block, so it has no valid/ready handshake. Every pin is a plain control or status signal.

Top module: `spi_chan_status`

## Requirements
- R1: The status word has these fields. Bit 0 is receive-register-full (`rx_held`), bit 1 is transmit-register-empty (`tx_free`), bit 2 is end-of-transfer (`xfer_end`), bit 3 is TX FIFO empty, bit 4 is TX FIFO full, bit 5 is RX FIFO empty and bit 6 is RX FIFO full. Bits 31 to 7 always read 0.
- R2: A synchronous active-high reset makes the status word 0 on the next edge, whatever the other inputs are.
- R3: `tx_free` becomes 1 on the edge after `chan_en` or after `shift_load`.
- R4: `tx_free` becomes 0 on the edge after a host transmit write to the most significant byte, when no higher-priority event occurs. The most significant byte index is WORD_BITS/8-1. Writes to any other byte index leave `tx_free` unchanged.
- R5: `rx_held` becomes 1 on the edge after `rx_capture`, unless `chan_en` is also asserted.
- R6: `rx_held` becomes 0 on the edge after `chan_en`, or after a host receive read of the most significant byte. Reads of other byte indices leave it unchanged.
- R7: Same-cycle conflicts are resolved as follows. `chan_en` wins over every other event for `tx_free` and `rx_held`. Among the rest, a shifter event (`shift_load`, `rx_capture`) wins over a host access.
- R8: `xfer_end` becomes 0 on the edge after `shift_load` and 1 on the edge after `xfer_done`. If both arrive together, `shift_load` wins and the flag becomes 0.
- R9: Each FIFO flag bit equals its level input as sampled on the previous clock edge, with 1 meaning full or empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_en | input | 1 | Channel enable strobe |
| tx_wr_en | input | 1 | Host write strobe to the transmit register |
| tx_wr_byte | input | IDX_W | Byte index of the host transmit write |
| rx_rd_en | input | 1 | Host read strobe from the receive register |
| rx_rd_byte | input | IDX_W | Byte index of the host receive read |
| shift_load | input | 1 | Transmit word moved into the shift register (transfer start) |
| rx_capture | input | 1 | Received word moved into the receive register |
| xfer_done | input | 1 | SPI transfer finished |
| txq_empty | input | 1 | TX FIFO empty level |
| txq_full | input | 1 | TX FIFO full level |
| rxq_empty | input | 1 | RX FIFO empty level |
| rxq_full | input | 1 | RX FIFO full level |
| stat_word | output | 32 | Read-only status word |

## Verification
The bench builds the block with WORD_BITS = 32, so the byte index is two bits wide and byte 3 is the most significant. This setting gives three distinct lower byte indices whose accesses must leave the flags alone. It also gives a most significant byte index that a wrong derivation from the word size (for example, using 1 as the top byte) would miss. Random strobes from a fixed seed produce many same-cycle collisions of enable, shifter and host events. Directed steps pin down each priority case and the case where load and transfer end coincide.

// File: rtl/spi_stat_pkg.sv
package spi_stat_pkg;

  localparam int unsigned STAT_W = 32;

  // Field view of the low bits of the status word; bit 0 is the last member.
  typedef struct packed {
    logic rxq_full;
    logic rxq_empty;
    logic txq_full;
    logic txq_empty;
    logic xfer_end;
    logic tx_free;
    logic rx_held;
  } stat_fields_t;

  localparam int unsigned FIELD_W = $bits(stat_fields_t);
  localparam int unsigned LVL_CNT = 4;

  // Width of a byte index for a word of wb bits (at least one bit).
  function automatic int unsigned byte_idx_w(input int unsigned wb);
    int unsigned n;
    n = wb / 8;
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/spi_msb_decode.sv
module spi_msb_decode
  import spi_stat_pkg::*;
#(
  parameter int unsigned WORD_BITS = 16,
  localparam int unsigned IDX_W = byte_idx_w(WORD_BITS),
  localparam int unsigned MSB_IDX = WORD_BITS / 8 - 1
) (
  input  logic             acc_en,
  input  logic [IDX_W-1:0] acc_idx,
  output logic             msb_hit
);

  assign msb_hit = acc_en && (acc_idx == IDX_W'(MSB_IDX));

endmodule

// File: rtl/spi_flag_cell.sv
module spi_flag_cell (
  input  logic clk,
  input  logic rst,
  input  logic p0_en,
  input  logic p0_val,
  input  logic p1_en,
  input  logic p1_val,
  input  logic p2_en,
  input  logic p2_val,
  output logic q
);

  logic q_nxt;

  // Three-level priority: p0 over p1 over p2, otherwise hold.
  always_comb begin
    q_nxt = q;
    if (p0_en)      q_nxt = p0_val;
    else if (p1_en) q_nxt = p1_val;
    else if (p2_en) q_nxt = p2_val;
  end

  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= q_nxt;
  end

endmodule

// File: rtl/spi_lvl_mirror.sv
module spi_lvl_mirror #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] lvl_in,
  output logic [N-1:0] lvl_q
);

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) lvl_q[i] <= 1'b0;
      else     lvl_q[i] <= lvl_in[i];
    end
  end

endmodule

// File: rtl/spi_chan_status.sv
module spi_chan_status
  import spi_stat_pkg::*;
#(
  parameter int unsigned WORD_BITS = 16,
  localparam int unsigned IDX_W = byte_idx_w(WORD_BITS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              chan_en,
  input  logic              tx_wr_en,
  input  logic [IDX_W-1:0]  tx_wr_byte,
  input  logic              rx_rd_en,
  input  logic [IDX_W-1:0]  rx_rd_byte,
  input  logic              shift_load,
  input  logic              rx_capture,
  input  logic              xfer_done,
  input  logic              txq_empty,
  input  logic              txq_full,
  input  logic              rxq_empty,
  input  logic              rxq_full,
  output logic [STAT_W-1:0] stat_word
);

  logic wr_msb;
  logic rd_msb;
  logic [LVL_CNT-1:0] lvl_q;
  stat_fields_t fld;

  spi_msb_decode #(.WORD_BITS(WORD_BITS)) u_wr_dec (
    .acc_en  (tx_wr_en),
    .acc_idx (tx_wr_byte),
    .msb_hit (wr_msb)
  );

  spi_msb_decode #(.WORD_BITS(WORD_BITS)) u_rd_dec (
    .acc_en  (rx_rd_en),
    .acc_idx (rx_rd_byte),
    .msb_hit (rd_msb)
  );

  // Transmit register empty: enable, then shifter load, then host MSB write.
  spi_flag_cell u_tx_free (
    .clk (clk), .rst (rst),
    .p0_en (chan_en),    .p0_val (1'b1),
    .p1_en (shift_load), .p1_val (1'b1),
    .p2_en (wr_msb),     .p2_val (1'b0),
    .q (fld.tx_free)
  );

  // Receive register full: enable, then capture, then host MSB read.
  spi_flag_cell u_rx_held (
    .clk (clk), .rst (rst),
    .p0_en (chan_en),    .p0_val (1'b0),
    .p1_en (rx_capture), .p1_val (1'b1),
    .p2_en (rd_msb),     .p2_val (1'b0),
    .q (fld.rx_held)
  );

  // End of transfer: a new load outranks the end of the previous transfer.
  spi_flag_cell u_xfer_end (
    .clk (clk), .rst (rst),
    .p0_en (shift_load), .p0_val (1'b0),
    .p1_en (xfer_done),  .p1_val (1'b1),
    .p2_en (1'b0),       .p2_val (1'b0),
    .q (fld.xfer_end)
  );

  spi_lvl_mirror #(.N(LVL_CNT)) u_lvl (
    .clk    (clk),
    .rst    (rst),
    .lvl_in ({rxq_full, rxq_empty, txq_full, txq_empty}),
    .lvl_q  (lvl_q)
  );

  assign fld.txq_empty = lvl_q[0];
  assign fld.txq_full  = lvl_q[1];
  assign fld.rxq_empty = lvl_q[2];
  assign fld.rxq_full  = lvl_q[3];

  assign stat_word = {{(STAT_W - FIELD_W){1'b0}}, fld};

endmodule

// File: rtl/spi_chan_status_sva.sv
module spi_chan_status_sva
  import spi_stat_pkg::*;
#(
  parameter int unsigned WORD_BITS = 16,
  localparam int unsigned IDX_W = byte_idx_w(WORD_BITS),
  localparam int unsigned MSB_IDX = WORD_BITS / 8 - 1
) (
  input logic              clk,
  input logic              rst,
  input logic              chan_en,
  input logic              tx_wr_en,
  input logic [IDX_W-1:0]  tx_wr_byte,
  input logic              rx_rd_en,
  input logic [IDX_W-1:0]  rx_rd_byte,
  input logic              shift_load,
  input logic              rx_capture,
  input logic              xfer_done,
  input logic              txq_empty,
  input logic              txq_full,
  input logic              rxq_empty,
  input logic              rxq_full,
  input logic [STAT_W-1:0] stat_word
);

  assert_upper_zero_R1: assert property (@(posedge clk) disable iff (rst)
    stat_word[STAT_W-1:FIELD_W] == '0);

  assert_txfree_set_R3: assert property (@(posedge clk) disable iff (rst)
    (chan_en || shift_load) |=> stat_word[1]);

  assert_txfree_clr_R4: assert property (@(posedge clk) disable iff (rst)
    (tx_wr_en && tx_wr_byte == IDX_W'(MSB_IDX) && !chan_en && !shift_load)
    |=> !stat_word[1]);

  assert_txfree_lowbyte_R4: assert property (@(posedge clk) disable iff (rst)
    (!(tx_wr_en && tx_wr_byte == IDX_W'(MSB_IDX)) && !chan_en && !shift_load)
    |=> $stable(stat_word[1]));

  assert_rxheld_set_R5: assert property (@(posedge clk) disable iff (rst)
    (rx_capture && !chan_en) |=> stat_word[0]);

  assert_rxheld_en_R7: assert property (@(posedge clk) disable iff (rst)
    chan_en |=> !stat_word[0]);

  assert_rxheld_lowbyte_R6: assert property (@(posedge clk) disable iff (rst)
    (!(rx_rd_en && rx_rd_byte == IDX_W'(MSB_IDX)) && !chan_en && !rx_capture)
    |=> $stable(stat_word[0]));

  assert_xferend_clr_R8: assert property (@(posedge clk) disable iff (rst)
    shift_load |=> !stat_word[2]);

  assert_xferend_set_R8: assert property (@(posedge clk) disable iff (rst)
    (xfer_done && !shift_load) |=> stat_word[2]);

  assert_lvl_mirror_R9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (stat_word[6:3] == $past({rxq_full, rxq_empty, txq_full, txq_empty})));

endmodule

bind spi_chan_status spi_chan_status_sva #(.WORD_BITS(WORD_BITS)) u_sva (
  .clk        (clk),
  .rst        (rst),
  .chan_en    (chan_en),
  .tx_wr_en   (tx_wr_en),
  .tx_wr_byte (tx_wr_byte),
  .rx_rd_en   (rx_rd_en),
  .rx_rd_byte (rx_rd_byte),
  .shift_load (shift_load),
  .rx_capture (rx_capture),
  .xfer_done  (xfer_done),
  .txq_empty  (txq_empty),
  .txq_full   (txq_full),
  .rxq_empty  (rxq_empty),
  .rxq_full   (rxq_full),
  .stat_word  (stat_word)
);

// File: tb/spi_chan_status_test.sv
`timescale 1ns/1ps
module spi_chan_status_test;

  localparam int unsigned WB = 32;
  localparam int unsigned IW = 2;
  localparam logic [IW-1:0] MSB = 2'd3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic chan_en = 0, tx_wr_en = 0, rx_rd_en = 0;
  logic [IW-1:0] tx_wr_byte = '0, rx_rd_byte = '0;
  logic shift_load = 0, rx_capture = 0, xfer_done = 0;
  logic txq_empty = 0, txq_full = 0, rxq_empty = 0, rxq_full = 0;
  logic [31:0] stat_word;

  int total = 0;
  int fails = 0;
  logic m_txf = 0, m_rxh = 0, m_eot = 0;
  logic [3:0] m_lvl = '0;

  always #5 clk = ~clk;

  spi_chan_status #(.WORD_BITS(WB)) uut (
    .clk (clk), .rst (rst), .chan_en (chan_en),
    .tx_wr_en (tx_wr_en), .tx_wr_byte (tx_wr_byte),
    .rx_rd_en (rx_rd_en), .rx_rd_byte (rx_rd_byte),
    .shift_load (shift_load), .rx_capture (rx_capture), .xfer_done (xfer_done),
    .txq_empty (txq_empty), .txq_full (txq_full),
    .rxq_empty (rxq_empty), .rxq_full (rxq_full),
    .stat_word (stat_word)
  );

  function automatic logic [31:0] exp_word();
    return {25'd0, m_lvl[3], m_lvl[2], m_lvl[1], m_lvl[0], m_eot, m_txf, m_rxh};
  endfunction

  function automatic logic nxt_txf(logic cur);
    if (chan_en || shift_load) return 1'b1;
    if (tx_wr_en && tx_wr_byte == MSB) return 1'b0;
    return cur;
  endfunction

  function automatic logic nxt_rxh(logic cur);
    if (chan_en) return 1'b0;
    if (rx_capture) return 1'b1;
    if (rx_rd_en && rx_rd_byte == MSB) return 1'b0;
    return cur;
  endfunction

  function automatic logic nxt_eot(logic cur);
    if (shift_load) return 1'b0;
    if (xfer_done) return 1'b1;
    return cur;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: status actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic clear_strobes();
    chan_en = 0; tx_wr_en = 0; rx_rd_en = 0;
    shift_load = 0; rx_capture = 0; xfer_done = 0;
  endtask

  // Inputs are already set (just after a rising edge); model, clock, check.
  task automatic tick(string tag);
    if (rst) begin
      m_txf = 0; m_rxh = 0; m_eot = 0; m_lvl = '0;
    end else begin
      m_txf = nxt_txf(m_txf);
      m_rxh = nxt_rxh(m_rxh);
      m_eot = nxt_eot(m_eot);
      m_lvl = {rxq_full, rxq_empty, txq_full, txq_empty};
    end
    @(posedge clk);
    #1;
    check(tag, stat_word, exp_word());
    clear_strobes();
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin : main
    int unsigned seed;
    seed = 32'h5eed_1234;
    void'($urandom(seed));

    // R2: reset wins over strobes and levels
    rst = 1; chan_en = 1; rx_capture = 1; xfer_done = 1;
    txq_empty = 1; txq_full = 1; rxq_empty = 1; rxq_full = 1;
    @(posedge clk); #1;
    chan_en = 1; rx_capture = 1; xfer_done = 1;
    tick("R2 reset");
    rst = 0;
    txq_empty = 1; txq_full = 0; rxq_empty = 1; rxq_full = 0;

    // R9: levels appear one edge later
    tick("R9 levels");
    txq_empty = 0; rxq_full = 1;
    tick("R9 levels change");

    chan_en = 1;               tick("R3 enable sets tx_free");
    tx_wr_en = 1; tx_wr_byte = 0; tick("R4 low byte 0 write");
    tx_wr_en = 1; tx_wr_byte = 1; tick("R4 low byte 1 write");
    tx_wr_en = 1; tx_wr_byte = 2; tick("R4 low byte 2 write");
    tx_wr_en = 1; tx_wr_byte = MSB; tick("R4 msb write clears");
    xfer_done = 1;             tick("R8 done sets xfer_end");
    shift_load = 1;            tick("R3 R8 load");
    xfer_done = 1; shift_load = 1; tick("R8 load beats done");
    rx_capture = 1;            tick("R5 capture");
    rx_rd_en = 1; rx_rd_byte = 0; tick("R6 low byte 0 read");
    rx_rd_en = 1; rx_rd_byte = 2; tick("R6 low byte 2 read");
    rx_rd_en = 1; rx_rd_byte = MSB; tick("R6 msb read clears");
    rx_capture = 1; rx_rd_en = 1; rx_rd_byte = MSB; tick("R7 capture beats read");
    tx_wr_en = 1; tx_wr_byte = MSB; tick("R4 msb write");
    shift_load = 1; tx_wr_en = 1; tx_wr_byte = MSB; tick("R7 load beats write");
    tx_wr_en = 1; tx_wr_byte = MSB; tick("R4 msb write again");
    chan_en = 1; rx_capture = 1; tx_wr_en = 1; tx_wr_byte = MSB;
    tick("R7 enable beats all");
    rx_capture = 1;            tick("R5 capture again");
    chan_en = 1;               tick("R6 enable clears rx_held");

    // Random mix: R1 R3 R4 R5 R6 R7 R8 R9
    for (int i = 0; i < 1500; i++) begin
      chan_en    = ($urandom % 16) == 0;
      tx_wr_en   = ($urandom % 3) == 0;
      tx_wr_byte = IW'($urandom);
      rx_rd_en   = ($urandom % 3) == 0;
      rx_rd_byte = IW'($urandom);
      shift_load = ($urandom % 5) == 0;
      rx_capture = ($urandom % 5) == 0;
      xfer_done  = ($urandom % 4) == 0;
      {rxq_full, rxq_empty, txq_full, txq_empty} = 4'($urandom);
      tick("R1 R3 R4 R5 R6 R7 R8 R9 random");
    end

    // R2: reset mid-run clears a busy status
    rst = 1; tick("R2 reset mid-run");
    rst = 0;

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule